// File: doc/BRIEF.md
# SHA-256 Message Schedule Update Unit

This unit computes four new SHA-256 message schedule words from 128-bit vectors of earlier schedule words. Each vector holds four 32-bit lanes. Lane e occupies bits [32e+31:32e], so lane 0 is the least significant. The work is split into two partial steps, and a one-bit op select chooses between them. Part 1 adds the small sigma0 term of the next-later word to each word. Part 2 completes the sum with the small sigma1 term. In part 2 the upper two lanes are computed from the lower two lanes of the same result, so the lanes depend on each other inside one operation.

Each operation is framed by a valid strobe and has one cycle of latency. The inputs are sampled on the clock edge where `in_valid` is high. The result is then registered and presented with `out_valid`. Between operations the output register holds its last value.

Top module: `msched_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `out_valid` is 0 and `out_word` is all zeros.
- R2: `out_valid` is high in exactly the cycles that follow a clock edge at which `in_valid` was high. The latency is therefore one cycle.
- R3: With `in_op` = 0 (part 1), lane e of the result is src_a[e] + s0(n). Here n is src_a[e+1] for e = 0..2 and src_b[0] for e = 3. The function is s0(x) = ror(x,7) ^ ror(x,18) ^ (x >> 3), where the shift is logical.
- R4: With `in_op` = 0, `src_c` has no effect on the result.
- R5: With `in_op` = 1 (part 2), lanes 0 and 1 of the result are s1(src_c[e+2]) + src_a[e] + src_b[e+1]. The function is s1(x) = ror(x,17) ^ ror(x,19) ^ (x >> 10).
- R6: With `in_op` = 1, lane 2 is s1(result[0]) + src_a[2] + src_b[3], and lane 3 is s1(result[1]) + src_a[3] + src_c[0]. Both use the freshly computed lanes of the same result.
- R7: Every addition wraps modulo 2^32 within its lane, and no carry passes between lanes.
- R8: In a cycle after an edge with `in_valid` low, `out_word` keeps its previous value, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request; inputs are sampled on this edge |
| in_op | input | 1 | 0 = part 1 (sigma0 step), 1 = part 2 (sigma1 step) |
| src_a | input | 128 | Words W0..W3 (both parts) |
| src_b | input | 128 | Part 1: W4..W7; part 2: W8..W11 |
| src_c | input | 128 | Part 2: W12..W15; ignored in part 1 |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_word | output | 128 | Four result lanes |

## Verification
A wrong lane pairing or a wrong rotation amount corrupts only particular lanes of `out_word`. That error is visible in the cycle after the request. Random operand patterns catch it almost at once, because each lane mixes distinct words.

A broken chain in part 2 shows up as wrong lanes 2 and 3 while lanes 0 and 1 stay correct. A missing wrap or a carry leaking between lanes shows up with all-ones operands. A bad hold or valid path shows up at the first idle cycle: `out_word` changes, or `out_valid` is wrong, even though no request was made.

// File: rtl/msched_unit.sv
module msched_unit (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_op,
  input  logic [127:0] src_a,
  input  logic [127:0] src_b,
  input  logic [127:0] src_c,
  output logic         out_valid,
  output logic [127:0] out_word
);
  localparam int LW    = 32;
  localparam int NL    = 4;
  localparam int VW    = LW * NL;

  function automatic logic [LW-1:0] rotr(input logic [LW-1:0] x, input int n);
    return (x >> n) | (x << (LW - n));
  endfunction

  function automatic logic [LW-1:0] sig_lo(input logic [LW-1:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [LW-1:0] sig_hi(input logic [LW-1:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  logic [LW-1:0] a [NL];
  logic [LW-1:0] b [NL];
  logic [LW-1:0] c [NL];
  logic [LW-1:0] p1 [NL];
  logic [LW-1:0] p2 [NL];
  logic [VW-1:0] p1_vec, p2_vec;

  for (genvar e = 0; e < NL; e++) begin : g_split
    assign a[e] = src_a[e*LW +: LW];
    assign b[e] = src_b[e*LW +: LW];
    assign c[e] = src_c[e*LW +: LW];
  end

  for (genvar e = 0; e < NL; e++) begin : g_part1
    if (e < NL - 1) begin : g_inner
      assign p1[e] = a[e] + sig_lo(a[e+1]);
    end else begin : g_edge
      assign p1[e] = a[e] + sig_lo(b[0]);
    end
    assign p1_vec[e*LW +: LW] = p1[e];
  end

  for (genvar e = 0; e < 2; e++) begin : g_part2_lo
    assign p2[e] = sig_hi(c[e+2]) + a[e] + b[e+1];
  end

  assign p2[2] = sig_hi(p2[0]) + a[2] + b[3];
  assign p2[3] = sig_hi(p2[1]) + a[3] + c[0];

  for (genvar e = 0; e < NL; e++) begin : g_pack2
    assign p2_vec[e*LW +: LW] = p2[e];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= in_op ? p2_vec : p1_vec;
    end
  end
endmodule

module msched_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_op,
  input logic [127:0] src_a,
  input logic [127:0] src_b,
  input logic [127:0] src_c,
  input logic         out_valid,
  input logic [127:0] out_word
);
  function automatic logic [31:0] s1f(input logic [31:0] x);
    return ((x >> 17) | (x << 15)) ^ ((x >> 19) | (x << 13)) ^ (x >> 10);
  endfunction

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> $stable(out_word));
  assert_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op) |=> out_word[31:0] ==
      s1f($past(src_c[95:64])) + $past(src_a[31:0]) + $past(src_b[63:32]));
  assert_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op) |=> out_word[95:64] ==
      s1f(out_word[31:0]) + $past(src_a[95:64]) + $past(src_b[127:96]));
endmodule

bind msched_unit msched_unit_chk u_chk (.*);

// File: tb/msched_unit_bench.sv
`timescale 1ns/1ps
module msched_unit_bench;
  logic clk = 0, rst_n = 0, in_valid = 0, in_op = 0;
  logic [127:0] src_a = '0, src_b = '0, src_c = '0;
  logic out_valid;
  logic [127:0] out_word;
  int checks = 0, errors = 0;
  logic [127:0] last;

  msched_unit u_msched_unit (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] s0(input logic [31:0] x);
    return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
  endfunction
  function automatic logic [31:0] s1(input logic [31:0] x);
    return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
  endfunction
  function automatic logic [31:0] ln(input logic [127:0] v, input int e);
    return v[e*32 +: 32];
  endfunction

  function automatic logic [127:0] ref1(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    for (int e = 0; e < 4; e++)
      r[e*32 +: 32] = ln(a, e) + s0(e < 3 ? ln(a, e + 1) : ln(b, 0));
    return r;
  endfunction

  function automatic logic [127:0] ref2(input logic [127:0] a, input logic [127:0] b,
                                        input logic [127:0] c);
    logic [31:0] r0, r1, r2, r3;
    r0 = s1(ln(c, 2)) + ln(a, 0) + ln(b, 1);
    r1 = s1(ln(c, 3)) + ln(a, 1) + ln(b, 2);
    r2 = s1(r0) + ln(a, 2) + ln(b, 3);
    r3 = s1(r1) + ln(a, 3) + ln(c, 0);
    return {r3, r2, r1, r0};
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run(input string req, input logic op, input logic [127:0] a,
                     input logic [127:0] b, input logic [127:0] c);
    @(negedge clk);
    in_valid = 1; in_op = op; src_a = a; src_b = b; src_c = c;
    @(negedge clk);
    in_valid = 0;
    check({req, " R2 valid"}, {127'd0, out_valid}, 128'd1);
    check(req, out_word, op ? ref2(a, b, c) : ref1(a, b));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] a, b, r;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {127'd0, out_valid}, 128'd0);
    check("R1 reset word", out_word, 128'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {127'd0, out_valid}, 128'd0);
    check("R1 after release word", out_word, 128'd0);

    run("R3 zeros", 0, '0, '0, '0);
    run("R3 single bit", 0, 128'h0000_0001_0000_0002_0000_0004_0000_0008,
        128'h8000_0000, '0);
    run("R7 part1 wrap", 0, {128{1'b1}}, {128{1'b1}}, '0);
    run("R7 part2 wrap", 1, {128{1'b1}}, {128{1'b1}}, {128{1'b1}});
    run("R5 directed", 1, 128'h1, 128'h2_0000_0000, 128'h1234_5678_0000_0000_0000_0000);
    run("R6 chain", 1, 128'h4444_4444_3333_3333_2222_2222_1111_1111,
        128'h8888_8888_7777_7777_6666_6666_5555_5555,
        128'hcccc_cccc_bbbb_bbbb_aaaa_aaaa_9999_9999);

    a = rnd(); b = rnd();
    run("R4 c=0", 0, a, b, '0);
    r = out_word;
    run("R4 c=ones", 0, a, b, {128{1'b1}});
    check("R4 same result", out_word, r);

    last = out_word;
    @(negedge clk);
    src_a = rnd(); src_b = rnd(); src_c = rnd(); in_op = ~in_op;
    @(negedge clk);
    check("R8 hold word", out_word, last);
    check("R2 idle valid", {127'd0, out_valid}, 128'd0);

    for (int i = 0; i < 300; i++) begin
      logic op;
      op = $urandom_range(1, 0);
      run(op ? "R5 R6 random" : "R3 random", op, rnd(), rnd(), rnd());
    end

    @(negedge clk);
    in_valid = 1; in_op = 0; src_a = rnd(); src_b = rnd();
    a = src_a; b = src_b;
    @(negedge clk);
    in_op = 1; src_a = rnd(); src_b = rnd(); src_c = rnd();
    check("R2 back-to-back 1", out_word, ref1(a, b));
    a = src_a; b = src_b; r = src_c;
    @(negedge clk);
    in_valid = 0;
    check("R2 back-to-back 2", out_word, ref2(a, b, r));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule